// File: doc/BRIEF.md
# Decode-Stage Branch Operand Forwarding Unit

This block sits beside the decode stage of an in-order pipeline whose branch comparator is evaluated in decode. For each of the two register sources of the instruction currently in decode, it decides where the comparator operand comes from. The choices are the register file, the result held in the execute/memory pipeline register, or the result held in the memory/writeback pipeline register. It also decides when a branch cannot resolve this cycle and must wait.

The unit is purely combinational. The select outputs steer two operand multiplexers in front of the comparator. The stall output holds the program counter and the fetch/decode register. The bubble output clears the control fields written into the decode/execute register, so that the waiting branch is not issued twice.

An instruction that is not a branch never requests forwarding or a stall from this unit. Forwarding for the ALU is handled elsewhere.

Top module: `branch_fwd_unit`

## Requirements
- R1: When `branch_i` is low, both selects are 2'b00 and `stall_o` and `bubble_o` are low, whatever the stage inputs are.
- R2: Select encoding per operand: 2'b00 register file, 2'b01 execute/memory result, 2'b10 memory/writeback result. The value 2'b11 never appears. Operand A follows source `rs_i` on `fwd_a_o`.
- R3: Operand B follows source `rt_i` on `fwd_b_o`, with the same rules and encoding as operand A.
- R4: The select is 2'b01 for a branch source equal to `exmem_rd_i` when `exmem_reg_write_i` is high and `exmem_mem_read_i` is low.
- R5: The select is 2'b10 for a branch source equal to `memwb_rd_i` when `memwb_reg_write_i` is high and the execute/memory stage does not write that same register.
- R6: When both later stages write the source register, the execute/memory stage wins. If that stage is a load, the select is 2'b00 and the branch stalls (R7).
- R7: A branch stalls when the execute/memory stage is a load (`exmem_mem_read_i` and `exmem_reg_write_i` high) whose destination equals either branch source.
- R8: A branch stalls when the decode/execute stage writes a register (`idex_reg_write_i` high) equal to either branch source.
- R9: Register 0 is never forwarded and never causes a stall. A source of 0 always selects 2'b00.
- R10: A stage whose register-write flag is low never forwards and never causes a stall.
- R11: `bubble_o` equals `stall_o` in every input state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| branch_i | input | 1 | Decode holds a branch |
| rs_i | input | REG_W | First source of the decode instruction |
| rt_i | input | REG_W | Second source of the decode instruction |
| idex_rd_i | input | REG_W | Destination in decode/execute register |
| idex_reg_write_i | input | 1 | Decode/execute instruction writes a register |
| exmem_rd_i | input | REG_W | Destination in execute/memory register |
| exmem_reg_write_i | input | 1 | Execute/memory instruction writes a register |
| exmem_mem_read_i | input | 1 | Execute/memory instruction is a load |
| memwb_rd_i | input | REG_W | Destination in memory/writeback register |
| memwb_reg_write_i | input | 1 | Memory/writeback instruction writes a register |
| fwd_a_o | output | 2 | Source select for comparator operand A |
| fwd_b_o | output | 2 | Source select for comparator operand B |
| stall_o | output | 1 | Hold PC and fetch/decode register |
| bubble_o | output | 1 | Clear control fields entering decode/execute |

## Verification
The unit holds no state, so a wrong decision shows at the ports in the same evaluation as the input pattern that causes it. The likely faults are a wrong priority between the two later stages, and forwarding from a load whose data is not ready yet. Either fault gives a select that differs from the expected value, or a missing stall, for that input pattern. Random stimulus draws register numbers from a narrow range, so that matches, double matches and register 0 occur often. Directed cases pin down each priority and exclusion rule.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_EXMEM = 2'b01,
    SEL_MEMWB = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/bfu_src_sel.sv
module bfu_src_sel
  import bfu_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             branch_i,
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] idex_rd_i,
  input  logic             idex_reg_write_i,
  input  logic [REG_W-1:0] exmem_rd_i,
  input  logic             exmem_reg_write_i,
  input  logic             exmem_mem_read_i,
  input  logic [REG_W-1:0] memwb_rd_i,
  input  logic             memwb_reg_write_i,
  output fwd_sel_e         sel_o,
  output logic             wait_o
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic src_live;
  logic hit_idex, hit_exmem, hit_memwb;

  assign src_live  = branch_i && (src_i != ZERO_REG);
  assign hit_idex  = src_live && idex_reg_write_i  && (idex_rd_i  == src_i);
  assign hit_exmem = src_live && exmem_reg_write_i && (exmem_rd_i == src_i);
  assign hit_memwb = src_live && memwb_reg_write_i && (memwb_rd_i == src_i);

  // youngest writer wins; a load in EX/MEM has no data yet
  always_comb begin
    sel_o = SEL_RF;
    if (hit_exmem) begin
      if (!exmem_mem_read_i) sel_o = SEL_EXMEM;
    end else if (hit_memwb) begin
      sel_o = SEL_MEMWB;
    end
  end

  assign wait_o = hit_idex || (hit_exmem && exmem_mem_read_i);
endmodule

// File: rtl/bfu_stall_ctl.sv
module bfu_stall_ctl
  import bfu_pkg::*;
(
  input  logic [NUM_SRC-1:0] wait_i,
  output logic               stall_o,
  output logic               bubble_o
);
  assign stall_o  = |wait_i;
  assign bubble_o = |wait_i;
endmodule

// File: rtl/branch_fwd_unit.sv
module branch_fwd_unit
  import bfu_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             branch_i,
  input  logic [REG_W-1:0] rs_i,
  input  logic [REG_W-1:0] rt_i,
  input  logic [REG_W-1:0] idex_rd_i,
  input  logic             idex_reg_write_i,
  input  logic [REG_W-1:0] exmem_rd_i,
  input  logic             exmem_reg_write_i,
  input  logic             exmem_mem_read_i,
  input  logic [REG_W-1:0] memwb_rd_i,
  input  logic             memwb_reg_write_i,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o,
  output logic             stall_o,
  output logic             bubble_o
);
  logic [NUM_SRC-1:0][REG_W-1:0] src_w;
  fwd_sel_e                      sel_w [NUM_SRC];
  logic [NUM_SRC-1:0]            wait_w;

  assign src_w = {rt_i, rs_i};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    bfu_src_sel #(.REG_W(REG_W)) u_sel (
      .branch_i          (branch_i),
      .src_i             (src_w[g]),
      .idex_rd_i         (idex_rd_i),
      .idex_reg_write_i  (idex_reg_write_i),
      .exmem_rd_i        (exmem_rd_i),
      .exmem_reg_write_i (exmem_reg_write_i),
      .exmem_mem_read_i  (exmem_mem_read_i),
      .memwb_rd_i        (memwb_rd_i),
      .memwb_reg_write_i (memwb_reg_write_i),
      .sel_o             (sel_w[g]),
      .wait_o            (wait_w[g])
    );
  end

  assign fwd_a_o = sel_w[0];
  assign fwd_b_o = sel_w[1];

  bfu_stall_ctl u_stall (
    .wait_i   (wait_w),
    .stall_o  (stall_o),
    .bubble_o (bubble_o)
  );
endmodule

// File: rtl/bfu_chk.sv
module bfu_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic             branch_i,
  input logic [REG_W-1:0] rs_i,
  input logic [REG_W-1:0] rt_i,
  input logic [REG_W-1:0] idex_rd_i,
  input logic             idex_reg_write_i,
  input logic [REG_W-1:0] exmem_rd_i,
  input logic             exmem_reg_write_i,
  input logic             exmem_mem_read_i,
  input logic [REG_W-1:0] memwb_rd_i,
  input logic             memwb_reg_write_i,
  input logic [1:0]       fwd_a_o,
  input logic [1:0]       fwd_b_o,
  input logic             stall_o,
  input logic             bubble_o
);
  always_comb begin
    // R1
    no_branch_quiet_chk: assert (branch_i || (fwd_a_o == 2'b00 && fwd_b_o == 2'b00 && !stall_o))
      else $error("activity without branch");
    // R2
    sel_a_legal_chk: assert (fwd_a_o != 2'b11) else $error("illegal select A");
    // R3
    sel_b_legal_chk: assert (fwd_b_o != 2'b11) else $error("illegal select B");
    // R4
    exmem_src_chk: assert (fwd_a_o != 2'b01 || (exmem_reg_write_i && !exmem_mem_read_i))
      else $error("EX/MEM forward without ALU write");
    // R5
    memwb_src_chk: assert (fwd_b_o != 2'b10 || memwb_reg_write_i)
      else $error("MEM/WB forward without write");
    // R9
    zero_src_chk: assert (rs_i != '0 || fwd_a_o == 2'b00)
      else $error("register 0 forwarded");
    // R10
    quiet_stages_chk: assert (idex_reg_write_i || exmem_reg_write_i || !stall_o)
      else $error("stall without a writer");
    // R11
    bubble_tracks_chk: assert (bubble_o == stall_o) else $error("bubble differs from stall");
  end
endmodule

bind branch_fwd_unit bfu_chk #(.REG_W(REG_W)) u_chk (
  .branch_i          (branch_i),
  .rs_i              (rs_i),
  .rt_i              (rt_i),
  .idex_rd_i         (idex_rd_i),
  .idex_reg_write_i  (idex_reg_write_i),
  .exmem_rd_i        (exmem_rd_i),
  .exmem_reg_write_i (exmem_reg_write_i),
  .exmem_mem_read_i  (exmem_mem_read_i),
  .memwb_rd_i        (memwb_rd_i),
  .memwb_reg_write_i (memwb_reg_write_i),
  .fwd_a_o           (fwd_a_o),
  .fwd_b_o           (fwd_b_o),
  .stall_o           (stall_o),
  .bubble_o          (bubble_o)
);

// File: tb/branch_fwd_unit_test.sv
module branch_fwd_unit_test;
  localparam int unsigned REG_W    = 5;
  localparam time         CLK_PER  = 10;
  localparam int unsigned N_RANDOM = 3000;
  localparam int unsigned WD_LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  logic             branch_i;
  logic [REG_W-1:0] rs_i, rt_i, idex_rd_i, exmem_rd_i, memwb_rd_i;
  logic             idex_reg_write_i, exmem_reg_write_i, exmem_mem_read_i, memwb_reg_write_i;
  logic [1:0]       fwd_a_o, fwd_b_o;
  logic             stall_o, bubble_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned cyc   = 0;
  logic        done  = 1'b0;

  branch_fwd_unit #(.REG_W(REG_W)) uut (
    .branch_i          (branch_i),
    .rs_i              (rs_i),
    .rt_i              (rt_i),
    .idex_rd_i         (idex_rd_i),
    .idex_reg_write_i  (idex_reg_write_i),
    .exmem_rd_i        (exmem_rd_i),
    .exmem_reg_write_i (exmem_reg_write_i),
    .exmem_mem_read_i  (exmem_mem_read_i),
    .memwb_rd_i        (memwb_rd_i),
    .memwb_reg_write_i (memwb_reg_write_i),
    .fwd_a_o           (fwd_a_o),
    .fwd_b_o           (fwd_b_o),
    .stall_o           (stall_o),
    .bubble_o          (bubble_o)
  );

  function automatic logic [1:0] exp_sel(input logic [REG_W-1:0] s);
    if (!branch_i || s == '0) return 2'b00;
    if (exmem_reg_write_i && exmem_rd_i == s) return exmem_mem_read_i ? 2'b00 : 2'b01;
    if (memwb_reg_write_i && memwb_rd_i == s) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic exp_wait(input logic [REG_W-1:0] s);
    if (!branch_i || s == '0) return 1'b0;
    return (idex_reg_write_i && idex_rd_i == s) ||
           (exmem_reg_write_i && exmem_mem_read_i && exmem_rd_i == s);
  endfunction

  task automatic drive(input logic br, input int rs, input int rt,
                       input int ir, input logic iw,
                       input int er, input logic ew, input logic el,
                       input int mr, input logic mw);
    @(posedge clk);
    branch_i = br; rs_i = rs[REG_W-1:0]; rt_i = rt[REG_W-1:0];
    idex_rd_i = ir[REG_W-1:0]; idex_reg_write_i = iw;
    exmem_rd_i = er[REG_W-1:0]; exmem_reg_write_i = ew; exmem_mem_read_i = el;
    memwb_rd_i = mr[REG_W-1:0]; memwb_reg_write_i = mw;
  endtask

  task automatic check(input string tag);
    logic [1:0] ea, eb;
    logic       es;
    @(negedge clk);
    ea = exp_sel(rs_i);
    eb = exp_sel(rt_i);
    es = exp_wait(rs_i) || exp_wait(rt_i);
    n_chk++;
    if (fwd_a_o !== ea || fwd_b_o !== eb || stall_o !== es || bubble_o !== es) begin
      n_bad++;
      $display("FAIL %s: a=%b b=%b stall=%b bubble=%b expected a=%b b=%b stall=%b bubble=%b",
               tag, fwd_a_o, fwd_b_o, stall_o, bubble_o, ea, eb, es, es);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!done && cyc > WD_LIMIT) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20041007));
    branch_i = 0; rs_i = '0; rt_i = '0; idex_rd_i = '0; idex_reg_write_i = 0;
    exmem_rd_i = '0; exmem_reg_write_i = 0; exmem_mem_read_i = 0;
    memwb_rd_i = '0; memwb_reg_write_i = 0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    check("reset R1");

    // R1: non-branch with every stage matching
    drive(0, 3, 3, 3, 1, 3, 1, 1, 3, 1);      check("R1");
    // R4 / R2: EX/MEM ALU result to A
    drive(1, 4, 7, 0, 0, 4, 1, 0, 0, 0);      check("R4 R2");
    // R3: EX/MEM to B
    drive(1, 7, 4, 0, 0, 4, 1, 0, 0, 0);      check("R3");
    // R5: MEM/WB to both
    drive(1, 9, 9, 0, 0, 2, 1, 0, 9, 1);      check("R5");
    // R6: both later stages write rs, EX/MEM wins
    drive(1, 6, 1, 0, 0, 6, 1, 0, 6, 1);      check("R6");
    // R6/R7: load in EX/MEM shadows MEM/WB, stall
    drive(1, 6, 1, 0, 0, 6, 1, 1, 6, 1);      check("R6 R7");
    // R7: load two ahead on rt
    drive(1, 2, 5, 0, 0, 5, 1, 1, 0, 0);      check("R7");
    // R7: load not matching, no stall
    drive(1, 2, 5, 0, 0, 8, 1, 1, 0, 0);      check("R7 nomatch");
    // R8: ID/EX ALU writer one ahead
    drive(1, 11, 12, 12, 1, 0, 0, 0, 0, 0);   check("R8");
    // R9: register 0 everywhere
    drive(1, 0, 0, 0, 1, 0, 1, 1, 0, 1);      check("R9");
    // R10: matching stages with writes off
    drive(1, 3, 3, 3, 0, 3, 0, 1, 3, 0);      check("R10");
    // R11: stall and bubble together, both operands forwarded differently
    drive(1, 13, 14, 13, 1, 14, 1, 0, 13, 1); check("R11");

    for (int i = 0; i < N_RANDOM; i++) begin
      drive($urandom_range(0, 3) != 0,
            $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 3), 1'($urandom),
            $urandom_range(0, 3), 1'($urandom), 1'($urandom),
            $urandom_range(0, 3), 1'($urandom));
      check("random R2 R3 R4 R5 R6 R7 R8 R9 R10 R11");
    end
    finish_run();
  end
endmodule